// File: doc/BRIEF.md
# Byte-lane asynchronous SRAM controller

This block runs on a system clock and converts single-word host requests into the strobe sequences required by an asynchronous static RAM. The RAM holds 524288 words of 16 bits. Each request carries a word address, write data, a per-byte enable mask and a read/write flag. The host presents a request with `host_valid`, and the controller takes it when `host_ready` is high. A read is answered with `host_rdata` and a single-cycle `host_rvalid` pulse.

On the memory side the controller registers every pin. Both chip selects are held active for as long as the controller is out of reset. When no access is in progress, both byte strobes are high, which puts the RAM in standby. A write is the period in which write enable and a byte strobe are low together. The write ends when write enable rises. The data bus output enable keeps the controller off the bus whenever the RAM may be driving it.

All minimum timings are parameters in nanoseconds. Each is rounded up to whole clock periods, with a minimum of one. From these counts the controller derives how long every phase lasts: a one-cycle SETUP, a STROBE phase, a HOLD phase and a one-cycle DONE.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While `rst_n` is low, `mem_we_n`, `mem_oe_n` and both bits of `mem_be_n` are 1, `mem_dq_oe` is 0, `mem_cs_n` is 1 and `mem_cs` is 0.
- R2: Whenever `host_ready` is 1, both byte strobes, `mem_we_n` and `mem_oe_n` are high. `host_ready` is 1 after reset and whenever no access is in progress.
- R3: A write holds `mem_we_n` low for exactly WS cycles. WS is the largest of the following: ceil(tWP/T), ceil(tDS/T), ceil(tCW/T)-1 and ceil(tBW/T)-1, where T is the clock period. With the default parameters WS is 5. `mem_addr` does not change while any byte strobe is low.
- R4: `mem_oe_n` never goes low while `mem_dq_oe` is 1. During a write, `mem_dq_oe` is high for exactly WS+2 consecutive cycles: SETUP, STROBE, and the first cycle after `mem_we_n` rises. It covers every cycle in which `mem_we_n` is low.
- R5: A read keeps `mem_we_n` high and holds `mem_oe_n` low for exactly RS cycles. RS is the largest of the following: ceil(tAA/T)-1, ceil(tRC/T)-1, ceil(tOE/T) and 1. With the default parameters RS is 6.
- R6: Read data is sampled from `mem_dq_i` on the last cycle in which `mem_oe_n` is low. `host_rvalid` is high for exactly one cycle. Counting falling edges after the accepting rising edge, the pulse falls on edge number RS+3.
- R7: Bit 0 of `host_be` and `mem_be_n[0]` control data bits 7..0, and bit 1 controls data bits 15..8. A strobe is driven low only for an enabled byte. A byte that is not enabled keeps its stored value on a write and reads back as zero. A write with mask 00 changes nothing.
- R8: A request is taken only on a rising edge at which `host_ready` is 1. While an access is in progress, `host_valid` and the request fields are ignored.
- R9: A write occupies the controller for 1+WS+WH+1 cycles. WH is ceil(tWC/T)-1-WS, with a minimum of 1. A read occupies it for 1+RS+1+1 cycles. After that, `host_ready` is 1 again.
- R10: Once reset has been released for one clock edge, `mem_cs_n` stays 0 and `mem_cs` stays 1. `mem_we_n` is low only while both selects are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Request present |
| host_ready | output | 1 | Controller can take a request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte enables, bit 0 = low byte |
| host_rdata | output | 16 | Read data, disabled bytes zero |
| host_rvalid | output | 1 | One-cycle read data valid |
| mem_addr | output | 19 | RAM address |
| mem_dq_o | output | 16 | Data toward the RAM |
| mem_dq_i | input | 16 | Data from the RAM |
| mem_dq_oe | output | 1 | Enables the controller's data drivers |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_be_n | output | 2 | Active-low byte strobes, bit 0 = low byte |

## Verification
Assertions check the following on every cycle:
- there is no bus contention between `mem_dq_oe` and `mem_oe_n`;
- data is driven throughout each write-enable pulse, and each pulse lasts exactly WS cycles;
- write enable is low only while the chip is selected;
- the pins are in standby whenever `host_ready` is high;
- the address stays put while a strobe is low;
- `host_rvalid` is a single-cycle pulse.

Only the bench's scenarios can show the following:
- data written through masked lanes really lands in the right byte;
- disabled bytes read back as zero;
- a mask of 00 leaves memory untouched;
- requests held up while the controller is busy leave no trace;
- the occupancy and read latency match the counts derived from the nanosecond parameters.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STROBE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_DONE   = 3'd4
  } ctrl_state_e;

  // Nanoseconds to clock cycles, rounded up, never below one.
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Write-enable low time: pulse width, data setup, and select/strobe-to-end
  // (strobes and selects already lead by the one SETUP cycle).
  function automatic int unsigned wr_strobe_len(input int unsigned wp, input int unsigned ds,
                                                input int unsigned cw, input int unsigned bw);
    return umax(umax(wp, ds), umax(umax(cw, 1) - 1, umax(bw, 1) - 1));
  endfunction

  // Cycles after write enable rises so that the whole write cycle is met.
  function automatic int unsigned wr_hold_len(input int unsigned wc, input int unsigned ws);
    return (wc > ws + 1) ? (wc - ws - 1) : 1;
  endfunction

  // Output-enable low time for a read: address access and cycle time minus
  // the SETUP cycle, output-enable access in full.
  function automatic int unsigned rd_strobe_len(input int unsigned aa, input int unsigned rc,
                                                input int unsigned oe);
    return umax(umax(umax(aa, 1) - 1, umax(rc, 1) - 1), umax(oe, 1));
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned LANES     = 2,
  parameter int unsigned WR_STROBE = 5,
  parameter int unsigned WR_HOLD   = 1,
  parameter int unsigned RD_STROBE = 6,
  parameter int unsigned RD_HOLD   = 1,
  parameter int unsigned CNT_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output ctrl_state_e       state_q,
  output ctrl_state_e       state_d,
  output logic              op_wr,
  output logic              op_wr_d,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_wdata,
  output logic [LANES-1:0]  op_be,
  output logic [LANES-1:0]  op_be_d,
  output logic              hold_enter_d,
  output logic              last_strobe
);

  localparam logic [CNT_W-1:0] WS_LOAD = CNT_W'(WR_STROBE - 1);
  localparam logic [CNT_W-1:0] WH_LOAD = CNT_W'(WR_HOLD - 1);
  localparam logic [CNT_W-1:0] RS_LOAD = CNT_W'(RD_STROBE - 1);
  localparam logic [CNT_W-1:0] RH_LOAD = CNT_W'(RD_HOLD - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept;
  logic             cnt_zero;

  assign accept   = (state_q == ST_IDLE) && req_valid;
  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid) begin state_d = ST_SETUP; cnt_d = '0; end
      ST_SETUP:  begin state_d = ST_STROBE; cnt_d = op_wr ? WS_LOAD : RS_LOAD; end
      ST_STROBE: if (cnt_zero) begin state_d = ST_HOLD; cnt_d = op_wr ? WH_LOAD : RH_LOAD; end
                 else cnt_d = cnt_q - 1'b1;
      ST_HOLD:   if (cnt_zero) state_d = ST_DONE;
                 else cnt_d = cnt_q - 1'b1;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign op_wr_d      = accept ? req_wr : op_wr;
  assign op_be_d      = accept ? req_be : op_be;
  assign hold_enter_d = (state_d == ST_HOLD) && (state_q != ST_HOLD);
  assign last_strobe  = (state_q == ST_STROBE) && cnt_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      op_wr    <= 1'b0;
      op_addr  <= '0;
      op_wdata <= '0;
      op_be    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (accept) begin
        op_wr    <= req_wr;
        op_addr  <= req_addr;
        op_wdata <= req_wdata;
        op_be    <= req_be;
      end
    end
  end

  // R8: the request latch only moves on a taken request
  a_r8_latch_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(op_addr) && $stable(op_wdata) && $stable(op_be));

endmodule

// File: rtl/sram_pin_reg.sv
module sram_pin_reg
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned LANES     = 2,
  parameter int unsigned WR_STROBE = 5,
  parameter int unsigned CNT_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_state_e      state_d,
  input  logic             op_wr_d,
  input  logic [LANES-1:0] op_be_d,
  input  logic             hold_enter_d,
  output logic             sel_q,
  output logic             we_n_q,
  output logic             oe_n_q,
  output logic [LANES-1:0] be_n_q,
  output logic             dq_oe_q
);

  localparam int unsigned RUN_W = CNT_W + 1;

  logic strobe_phase_d, setup_phase_d;
  logic [RUN_W-1:0] we_low_run;

  assign strobe_phase_d = (state_d == ST_STROBE);
  assign setup_phase_d  = (state_d == ST_SETUP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      sel_q   <= 1'b1;
      we_n_q  <= !(strobe_phase_d && op_wr_d);
      oe_n_q  <= !(strobe_phase_d && !op_wr_d);
      dq_oe_q <= op_wr_d && (setup_phase_d || strobe_phase_d || hold_enter_d);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane_strobe
    always_ff @(posedge clk) begin
      if (!rst_n) be_n_q[g] <= 1'b1;
      else        be_n_q[g] <= !((setup_phase_d || strobe_phase_d) && op_be_d[g]);
    end
  end

  // Observation counter for the pulse-width check.
  always_ff @(posedge clk) begin
    if (!rst_n)       we_low_run <= '0;
    else if (!we_n_q) we_low_run <= we_low_run + 1'b1;
    else              we_low_run <= '0;
  end

  a_r4_no_bus_fight: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe_q |-> oe_n_q);
  a_r4_data_covers_we: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |-> dq_oe_q);
  a_r3_we_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_q) |-> (we_low_run == RUN_W'(WR_STROBE)));
  a_r10_write_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |-> sel_q);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_en,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] rdata
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane_cap
    always_ff @(posedge clk) begin
      if (!rst_n)          rdata[g*8 +: 8] <= '0;
      else if (capture_en) rdata[g*8 +: 8] <= lane_en[g] ? dq_i[g*8 +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_NS  = 10,
  parameter int unsigned ADDR_W  = 19,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned T_RC_NS = 70,
  parameter int unsigned T_AA_NS = 70,
  parameter int unsigned T_OE_NS = 35,
  parameter int unsigned T_WC_NS = 70,
  parameter int unsigned T_WP_NS = 50,
  parameter int unsigned T_CW_NS = 60,
  parameter int unsigned T_BW_NS = 60,
  parameter int unsigned T_DS_NS = 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_valid,
  output logic                host_ready,
  input  logic                host_wr,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [DATA_W-1:0]   host_wdata,
  input  logic [DATA_W/8-1:0] host_be,
  output logic [DATA_W-1:0]   host_rdata,
  output logic                host_rvalid,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_dq_o,
  input  logic [DATA_W-1:0]   mem_dq_i,
  output logic                mem_dq_oe,
  output logic                mem_cs_n,
  output logic                mem_cs,
  output logic                mem_we_n,
  output logic                mem_oe_n,
  output logic [DATA_W/8-1:0] mem_be_n
);

  localparam int unsigned LANES = DATA_W / 8;

  localparam int unsigned C_RC = ns2cyc(T_RC_NS, CLK_NS);
  localparam int unsigned C_AA = ns2cyc(T_AA_NS, CLK_NS);
  localparam int unsigned C_OE = ns2cyc(T_OE_NS, CLK_NS);
  localparam int unsigned C_WC = ns2cyc(T_WC_NS, CLK_NS);
  localparam int unsigned C_WP = ns2cyc(T_WP_NS, CLK_NS);
  localparam int unsigned C_CW = ns2cyc(T_CW_NS, CLK_NS);
  localparam int unsigned C_BW = ns2cyc(T_BW_NS, CLK_NS);
  localparam int unsigned C_DS = ns2cyc(T_DS_NS, CLK_NS);

  localparam int unsigned WR_STROBE = wr_strobe_len(C_WP, C_DS, C_CW, C_BW);
  localparam int unsigned WR_HOLD   = wr_hold_len(C_WC, WR_STROBE);
  localparam int unsigned RD_STROBE = rd_strobe_len(C_AA, C_RC, C_OE);
  localparam int unsigned RD_HOLD   = 1;
  localparam int unsigned MAX_LEN   = umax(umax(WR_STROBE, RD_STROBE), WR_HOLD);
  localparam int unsigned CNT_W     = $clog2(MAX_LEN + 1);

  ctrl_state_e       state_q, state_d;
  logic              op_wr, op_wr_d;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_wdata;
  logic [LANES-1:0]  op_be, op_be_d;
  logic              hold_enter_d, last_strobe;
  logic              sel_q, rd_capture_en;

  sram_ctrl_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES),
    .WR_STROBE(WR_STROBE), .WR_HOLD(WR_HOLD),
    .RD_STROBE(RD_STROBE), .RD_HOLD(RD_HOLD), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(host_valid), .req_wr(host_wr), .req_addr(host_addr),
    .req_wdata(host_wdata), .req_be(host_be),
    .state_q(state_q), .state_d(state_d),
    .op_wr(op_wr), .op_wr_d(op_wr_d), .op_addr(op_addr), .op_wdata(op_wdata),
    .op_be(op_be), .op_be_d(op_be_d),
    .hold_enter_d(hold_enter_d), .last_strobe(last_strobe)
  );

  sram_pin_reg #(
    .LANES(LANES), .WR_STROBE(WR_STROBE), .CNT_W(CNT_W)
  ) u_pins (
    .clk(clk), .rst_n(rst_n),
    .state_d(state_d), .op_wr_d(op_wr_d), .op_be_d(op_be_d), .hold_enter_d(hold_enter_d),
    .sel_q(sel_q), .we_n_q(mem_we_n), .oe_n_q(mem_oe_n), .be_n_q(mem_be_n), .dq_oe_q(mem_dq_oe)
  );

  assign rd_capture_en = last_strobe && !op_wr;

  sram_rd_capture #(
    .DATA_W(DATA_W), .LANES(LANES)
  ) u_rdcap (
    .clk(clk), .rst_n(rst_n),
    .capture_en(rd_capture_en), .lane_en(op_be), .dq_i(mem_dq_i), .rdata(host_rdata)
  );

  assign host_ready  = (state_q == ST_IDLE);
  assign host_rvalid = (state_q == ST_DONE) && !op_wr;
  assign mem_addr    = op_addr;
  assign mem_dq_o    = op_wdata;
  assign mem_cs_n    = !sel_q;
  assign mem_cs      = sel_q;

  a_r2_idle_standby: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> (&mem_be_n) && mem_we_n && mem_oe_n);
  a_r6_rvalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |=> !host_rvalid);
  a_r3_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !(&mem_be_n) |=> (&mem_be_n) || $stable(mem_addr));
  a_r10_select_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> !mem_cs_n && mem_cs);

endmodule

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_valid = 1'b0, h_wr = 1'b0;
  logic [AW-1:0] h_addr = '0;
  logic [DW-1:0] h_wdata = '0;
  logic [1:0] h_be = '0;
  logic h_ready, h_rvalid;
  logic [DW-1:0] h_rdata;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_dq_o, m_dq_i;
  logic m_dq_oe, m_cs_n, m_cs, m_we_n, m_oe_n;
  logic [1:0] m_be_n;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_lane_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .host_valid(h_valid), .host_ready(h_ready), .host_wr(h_wr), .host_addr(h_addr),
    .host_wdata(h_wdata), .host_be(h_be), .host_rdata(h_rdata), .host_rvalid(h_rvalid),
    .mem_addr(m_addr), .mem_dq_o(m_dq_o), .mem_dq_i(m_dq_i), .mem_dq_oe(m_dq_oe),
    .mem_cs_n(m_cs_n), .mem_cs(m_cs), .mem_we_n(m_we_n), .mem_oe_n(m_oe_n), .mem_be_n(m_be_n)
  );

  // Expected timing restated from the requirements.
  function automatic int cyc(input int ns);
    int c = ns / CLK_PERIOD;
    if (c * CLK_PERIOD < ns) c++;
    return (c == 0) ? 1 : c;
  endfunction
  function automatic int big(input int a, input int b);
    return (a >= b) ? a : b;
  endfunction
  function automatic int exp_ws();
    return big(big(cyc(50), cyc(30)), big(cyc(60) - 1, cyc(60) - 1));
  endfunction
  function automatic int exp_wh();
    return big(cyc(70) - 1 - exp_ws(), 1);
  endfunction
  function automatic int exp_rs();
    return big(big(cyc(70) - 1, cyc(70) - 1), big(cyc(35), 1));
  endfunction

  // Memory model and shadow copy.
  logic [DW-1:0] mem_model [int];
  logic [DW-1:0] shadow [int];
  function automatic logic [DW-1:0] peek(input int a);
    return mem_model.exists(a) ? mem_model[a] : 16'h0000;
  endfunction
  function automatic logic [DW-1:0] shadow_get(input int a);
    return shadow.exists(a) ? shadow[a] : 16'h0000;
  endfunction
  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic [1:0] be);
    logic [DW-1:0] r = old;
    if (be[0]) r[7:0]  = nw[7:0];
    if (be[1]) r[15:8] = nw[15:8];
    return r;
  endfunction
  function automatic logic [DW-1:0] keep_lanes(input logic [DW-1:0] v, input logic [1:0] be);
    return {be[1] ? v[15:8] : 8'h00, be[0] ? v[7:0] : 8'h00};
  endfunction

  always_comb begin
    logic [DW-1:0] w;
    m_dq_i = 16'hA5C3;
    w = peek(int'(m_addr));
    if (!m_cs_n && m_cs && m_we_n && !m_oe_n) begin
      if (!m_be_n[0]) m_dq_i[7:0]  = w[7:0];
      if (!m_be_n[1]) m_dq_i[15:8] = w[15:8];
    end
  end

  // Pin monitor.
  int we_run = 0, last_we_run = 0, oe_run = 0, last_oe_run = 0, dqoe_run = 0, last_dqoe_run = 0;
  int fight = 0, idle_busy = 0, addr_move = 0, desel = 0, undriven_wr = 0;
  logic [AW-1:0] prev_addr = '0;
  logic prev_strobe = 1'b0;
  logic mon_on = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (!m_we_n) we_run++; else if (we_run != 0) begin last_we_run = we_run; we_run = 0; end
      if (!m_oe_n) oe_run++; else if (oe_run != 0) begin last_oe_run = oe_run; oe_run = 0; end
      if (m_dq_oe) dqoe_run++; else if (dqoe_run != 0) begin last_dqoe_run = dqoe_run; dqoe_run = 0; end
      if (m_dq_oe && !m_oe_n) fight++;
      if (h_ready && (!(&m_be_n) || !m_we_n || !m_oe_n)) idle_busy++;
      if (!(&m_be_n) && prev_strobe && (m_addr != prev_addr)) addr_move++;
      if (m_cs_n || !m_cs) desel++;
      if (!m_cs_n && m_cs && !m_we_n) begin
        if (!m_dq_oe) undriven_wr++;
        mem_model[int'(m_addr)] = merge(peek(int'(m_addr)), m_dq_o, ~m_be_n);
      end
      prev_strobe = !(&m_be_n);
      prev_addr = m_addr;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One host transaction; hammer keeps valid high with junk while busy.
  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [1:0] be, input bit hammer,
                       output logic [DW-1:0] rd, output int rv_at, output int rdy_at);
    int n = 0;
    int pulses = 0;
    rd = '0; rv_at = -1;
    @(negedge clk);
    while (!h_ready) @(negedge clk);
    h_valid = 1'b1; h_wr = wr; h_addr = a; h_wdata = d; h_be = be;
    @(posedge clk);
    forever begin
      @(negedge clk);
      n++;
      if (hammer) begin
        h_valid = 1'b1; h_wr = 1'b1; h_addr = 19'h12345; h_wdata = 16'hFFFF; h_be = 2'b11;
      end else h_valid = 1'b0;
      if (h_rvalid) begin rd = h_rdata; rv_at = n; pulses++; end
      if (h_ready) begin h_valid = 1'b0; break; end
    end
    rdy_at = n;
    if (!wr) check(pulses == 1, "R6 rvalid pulse count", pulses, 1);
  endtask

  task automatic write_chk(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] be,
                           input bit hammer);
    logic [DW-1:0] rd;
    int rv, rdy;
    last_we_run = 0; last_dqoe_run = 0;
    do_op(1'b1, a, d, be, hammer, rd, rv, rdy);
    shadow[int'(a)] = merge(shadow_get(int'(a)), d, be);
    check(rdy == 1 + exp_ws() + exp_wh() + 1 + 1, "R9 write occupancy", rdy, 3 + exp_ws() + exp_wh());
    check(last_we_run == exp_ws(), "R3 we_n low cycles", last_we_run, exp_ws());
    check(last_dqoe_run == exp_ws() + 2, "R4 dq_oe window", last_dqoe_run, exp_ws() + 2);
  endtask

  task automatic read_chk(input logic [AW-1:0] a, input logic [1:0] be, input string req);
    logic [DW-1:0] rd;
    int rv, rdy;
    last_oe_run = 0;
    do_op(1'b0, a, 16'h0, be, 1'b0, rd, rv, rdy);
    check(rd == keep_lanes(shadow_get(int'(a)), be), req, int'(rd),
          int'(keep_lanes(shadow_get(int'(a)), be)));
    check(rv == exp_rs() + 3, "R6 rvalid timing", rv, exp_rs() + 3);
    check(rdy == exp_rs() + 4, "R9 read occupancy", rdy, exp_rs() + 4);
    check(last_oe_run == exp_rs(), "R5 oe_n low cycles", last_oe_run, exp_rs());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (2) @(negedge clk);
    // R1 reset state
    check(m_we_n && m_oe_n && (m_be_n == 2'b11), "R1 strobes idle in reset", {m_we_n, m_oe_n, m_be_n}, 4'hF);
    check(!m_dq_oe && m_cs_n && !m_cs, "R1 deselected in reset", {m_dq_oe, m_cs_n, m_cs}, 3'b010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    mon_on = 1'b1;
    check(h_ready, "R2 ready after reset", h_ready, 1);
    check(!m_cs_n && m_cs, "R10 selects active", {m_cs_n, m_cs}, 2'b01);
    check(m_be_n == 2'b11, "R2 standby strobes", m_be_n, 2'b11);

    // Directed corners
    write_chk(19'h00000, 16'h1234, 2'b11, 1'b0);
    write_chk(19'h7FFFF, 16'hBEEF, 2'b11, 1'b0);
    read_chk(19'h00000, 2'b11, "R6 read address 0");
    read_chk(19'h7FFFF, 2'b11, "R6 read top address");
    write_chk(19'h00000, 16'hAAFF, 2'b01, 1'b0);
    read_chk(19'h00000, 2'b11, "R7 low-lane write only");
    write_chk(19'h00000, 16'h55EE, 2'b10, 1'b0);
    read_chk(19'h00000, 2'b11, "R7 high-lane write only");
    write_chk(19'h7FFFF, 16'h0000, 2'b00, 1'b0);
    read_chk(19'h7FFFF, 2'b11, "R7 mask 00 write changes nothing");
    read_chk(19'h7FFFF, 2'b01, "R7 disabled upper reads zero");
    read_chk(19'h7FFFF, 2'b10, "R7 disabled lower reads zero");
    write_chk(19'h00010, 16'hC0DE, 2'b11, 1'b1);
    read_chk(19'h12345, 2'b11, "R8 busy request ignored");
    read_chk(19'h00010, 2'b11, "R8 accepted write intact");

    // Constrained random traffic
    for (int i = 0; i < 60; i++) begin
      logic [AW-1:0] a;
      logic [1:0] be;
      a = 19'h40000 + AW'($urandom % 24);
      be = 2'($urandom);
      if ($urandom % 2 == 0) write_chk(a, 16'($urandom), be, 1'($urandom % 4 == 0));
      else read_chk(a, be, "R7 random read lanes");
    end

    repeat (3) @(negedge clk);
    check(fight == 0, "R4 no bus contention", fight, 0);
    check(undriven_wr == 0, "R4 data driven during write", undriven_wr, 0);
    check(idle_busy == 0, "R2 idle pins in standby", idle_busy, 0);
    check(addr_move == 0, "R3 address steady under strobe", addr_move, 0);
    check(desel == 0, "R10 selects never dropped", desel, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule